// File: doc/BRIEF.md
# Seconds Watchdog with Selectable Expiry Action

This block is a watchdog timer with a two-register window. One register holds the control and status bits. The other holds the reload value in whole seconds and shows the live countdown. A prescaler divides the system clock into a one-cycle tick each second. While the watchdog runs, each tick lowers the countdown by one. Software keeps the system alive by setting a self-clearing trigger bit, which reloads the countdown. If the count reaches zero while the watchdog runs, the block sends out a one-cycle request pulse. A control bit chooses whether that pulse asks for a system reset or for power-off.

A flag records that the last restart came from expiry. This flag sits in the power-on reset domain, so the system reset that the block itself requests does not clear it. Two configuration inputs gate the block. `cfg_enable` allows counting. `cfg_access` opens the register window.

The sequencer has three states:
- `WD_STOPPED`: idle, with the count held.
- `WD_COUNTING`: the count falls on each tick.
- `WD_EXPIRED`: the count sits at zero after the request.

The transitions are:
- start, from `WD_STOPPED` to `WD_COUNTING`: run and enable are both set, and the count after the write is not zero.
- halt, from `WD_COUNTING` or `WD_EXPIRED` to `WD_STOPPED`: run or enable is cleared.
- expire, from `WD_COUNTING` to `WD_EXPIRED`: a tick arrives while the count is 1 and no trigger is present.
- rearm, from `WD_EXPIRED` to `WD_COUNTING`: a trigger arrives while the watchdog runs.
- reload: a trigger in `WD_COUNTING` stays in `WD_COUNTING`, with the count reloaded and the prescaler restarted.

Top module: `sec_watchdog`

## Requirements
- R1: After either reset, the block comes up as follows.
  - The control register reads 0, apart from bit 3.
  - The timeout register reads the default reload of 60 with a live count of 0.
  - Neither request output is asserted.
- R2: The register window is decoded from `reg_addr`.
  - Offset 0 is the control register.
  - Offset 4 holds the reload value in bits [9:0] and the live count in bits [25:16].
  - Every other offset reads 0 and ignores writes.
  - While `cfg_access` is 0, `reg_rdata` is 0 and all writes are ignored.
- R3: A write with control bit 7 set loads the live count from the reload value and restarts the prescaler. Bit 7 always reads back as 0.
- R4: While control bit 0 (run) and `cfg_enable` are both 1, the live count falls by one every `TICK_DIV` clock cycles.
- R5: Expiry produces a one-cycle request pulse `TICK_DIV`×T cycles after the trigger write edge, where T is the reload value.
  - The pulse appears on `rst_req` when control bit 2 is 0, and on `pwroff_req` when bit 2 is 1.
  - After expiry the count stays at 0 and no further pulse appears until the next trigger.
- R6: Clearing run, or driving `cfg_enable` low, holds the count and suppresses expiry. Restoring it resumes the countdown from the held count.
- R7: Control bit 3 is read-only and reads as the inverse of `cfg_enable`.
- R8: Control bit 1 behaves as follows.
  - It is set at expiry.
  - A write of 1 to bit 1 clears it.
  - It survives `sys_rst_n`.
  - Only `por_rst_n` resets it.
- R9: A write to offset 4 takes bits [9:0] as the reload value. A write whose value in bits [9:0] is 0 is ignored.
- R10: A trigger before expiry postpones expiry to a full reload period after that trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst_n | input | 1 | Asynchronous power-on reset, active low; clears everything |
| sys_rst_n | input | 1 | Asynchronous system reset, active low; spares the expiry flag |
| cfg_enable | input | 1 | Configuration gate allowing the countdown |
| cfg_access | input | 1 | Configuration gate opening the register window |
| reg_addr | input | 3 | Byte offset in the register window |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| rst_req | output | 1 | One-cycle system reset request |
| pwroff_req | output | 1 | One-cycle power-off request |

## Verification
The countdown is swept over reload values 1 to 6 with both expiry actions, plus the maximum of 1023. The sweep checks three things: that expiry lands on exactly T·`TICK_DIV` edges, that no pulse comes early, and that no second pulse follows. Separate patterns interrupt the countdown, one by clearing run and one by dropping `cfg_enable`. Each then resumes, which shows whether the held count or a fresh reload is used. A retrigger part-way through a countdown distinguishes a true reload from a count that keeps running. Pulsing the two resets separately distinguishes the domain of the expiry flag from that of the control bits.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef enum logic [1:0] {
        WD_STOPPED  = 2'd0,
        WD_COUNTING = 2'd1,
        WD_EXPIRED  = 2'd2
    } wd_state_e;

    // control register bit positions (software decodes these)
    localparam int CTL_RUN   = 0;
    localparam int CTL_FIRED = 1;
    localparam int CTL_PWR   = 2;
    localparam int CTL_DIS   = 3;
    localparam int CTL_TRIG  = 7;

    localparam logic [2:0] OFS_CTL = 3'd0;
    localparam logic [2:0] OFS_CNT = 3'd4;
    localparam int         LIVE_LSB = 16;
endpackage

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
    parameter int DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick = run && (pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr || !run || pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R4
    tick_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(run));
endmodule

// File: rtl/sw_regs.sv
module sw_regs
    import sw_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int DEF_TIMEOUT = 60
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_n,
    input  logic             acc_en,
    input  logic             wd_en,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    input  logic [CNT_W-1:0] live_cnt,
    input  logic             expire,
    output logic [31:0]      rdata,
    output logic             run_nxt,
    output logic             pwr_sel,
    output logic [CNT_W-1:0] reload,
    output logic             trig
);
    logic             rst_n;
    logic             run_q, pwr_q, fired_q;
    logic [CNT_W-1:0] reload_q;
    logic             wr_ctl, wr_cnt;
    logic             unused_wbits;

    assign rst_n        = por_n & sys_n;
    assign unused_wbits = ^wdata;
    assign wr_ctl       = wr_en && acc_en && (addr == OFS_CTL);
    assign wr_cnt       = wr_en && acc_en && (addr == OFS_CNT);
    assign trig         = wr_ctl && wdata[CTL_TRIG];
    assign run_nxt      = wr_ctl ? wdata[CTL_RUN] : run_q;
    assign pwr_sel      = pwr_q;
    assign reload       = reload_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            pwr_q    <= 1'b0;
            reload_q <= CNT_W'(DEF_TIMEOUT);
        end else begin
            if (wr_ctl) begin
                run_q <= wdata[CTL_RUN];
                pwr_q <= wdata[CTL_PWR];
            end
            if (wr_cnt && wdata[CNT_W-1:0] != '0) begin
                reload_q <= wdata[CNT_W-1:0];
            end
        end
    end

    // expiry flag lives in the power-on domain only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fired_q <= 1'b0;
        end else if (expire) begin
            fired_q <= 1'b1;
        end else if (wr_ctl && wdata[CTL_FIRED]) begin
            fired_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (acc_en) begin
            if (addr == OFS_CTL) begin
                rdata[CTL_RUN]   = run_q;
                rdata[CTL_FIRED] = fired_q;
                rdata[CTL_PWR]   = pwr_q;
                rdata[CTL_DIS]   = !wd_en;
            end else if (addr == OFS_CNT) begin
                rdata = (32'(live_cnt) << LIVE_LSB) | 32'(reload_q);
            end
        end
    end

    // R8
    fired_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(fired_q) |-> $past(wr_ctl && wdata[CTL_FIRED]));
    // R9
    reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && wdata[CNT_W-1:0] == '0) |=> $stable(reload_q));
endmodule

// File: rtl/sw_fsm.sv
module sw_fsm
    import sw_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             trig,
    input  logic             tick,
    input  logic             pwr_sel,
    input  logic [CNT_W-1:0] reload,
    output wd_state_e        state,
    output logic [CNT_W-1:0] live_cnt,
    output logic             expire,
    output logic             rst_req,
    output logic             pwroff_req
);
    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_after_wr;

    assign state        = state_q;
    assign live_cnt     = cnt_q;
    assign cnt_after_wr = trig ? reload : cnt_q;
    assign expire       = (state_q == WD_COUNTING) && go && tick && !trig
                          && (cnt_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_STOPPED:  if (go && cnt_after_wr != '0) state_d = WD_COUNTING;
            WD_COUNTING: if (!go)                      state_d = WD_STOPPED;
                         else if (expire)              state_d = WD_EXPIRED;
            WD_EXPIRED:  if (!go)                      state_d = WD_STOPPED;
                         else if (trig)                state_d = WD_COUNTING;
            default:                                   state_d = WD_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_STOPPED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= reload;
        end else if (tick && go && state_q == WD_COUNTING) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req    <= 1'b0;
            pwroff_req <= 1'b0;
        end else begin
            rst_req    <= expire && !pwr_sel;
            pwroff_req <= expire && pwr_sel;
        end
    end

    // R5
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || pwroff_req) |=> !(rst_req || pwroff_req));
    // R5
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && pwroff_req));
    // R5
    req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || pwroff_req) |-> state_q == WD_EXPIRED);
    // R5
    expired_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == WD_EXPIRED |-> cnt_q == '0);
    // R6
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WD_COUNTING && !trig) |=> $stable(cnt_q));
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
    import sw_pkg::*;
#(
    parameter int TICK_DIV    = 50_000_000,
    parameter int CNT_W       = 10,
    parameter int DEF_TIMEOUT = 60
) (
    input  logic        clk,
    input  logic        por_rst_n,
    input  logic        sys_rst_n,
    input  logic        cfg_enable,
    input  logic        cfg_access,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        rst_req,
    output logic        pwroff_req
);
    logic             core_rst_n;
    logic             run_nxt, pwr_sel, trig, tick, expire, go;
    logic [CNT_W-1:0] reload, live_cnt;
    wd_state_e        state;

    assign core_rst_n = por_rst_n & sys_rst_n;
    assign go         = run_nxt && cfg_enable;

    sw_regs #(.CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_regs (
        .clk(clk), .por_n(por_rst_n), .sys_n(sys_rst_n),
        .acc_en(cfg_access), .wd_en(cfg_enable),
        .addr(reg_addr), .wr_en(reg_wr), .wdata(reg_wdata),
        .live_cnt(live_cnt), .expire(expire), .rdata(reg_rdata),
        .run_nxt(run_nxt), .pwr_sel(pwr_sel), .reload(reload), .trig(trig)
    );

    sw_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(core_rst_n), .clr(trig),
        .run(state == WD_COUNTING), .tick(tick)
    );

    sw_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(core_rst_n), .go(go), .trig(trig), .tick(tick),
        .pwr_sel(pwr_sel), .reload(reload), .state(state),
        .live_cnt(live_cnt), .expire(expire),
        .rst_req(rst_req), .pwroff_req(pwroff_req)
    );
endmodule

// File: tb/sim_sec_watchdog.sv
`timescale 1ns/1ps
module sim_sec_watchdog;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        por_rst_n = 1'b0, sys_rst_n = 1'b0;
    logic        cfg_enable = 1'b1, cfg_access = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rst_req, pwroff_req;

    int checks = 0, errors = 0, n_rst = 0, n_pwr = 0;
    bit done = 0;

    sec_watchdog #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
        .cfg_enable(cfg_enable), .cfg_access(cfg_access),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rst_req(rst_req), .pwroff_req(pwroff_req)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst_req)    n_rst++;
        if (pwroff_req) n_pwr++;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr = a; reg_wr = 1'b0;
        #1 d = reg_rdata;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // pulse expected at the edge 'edges' after the one preceding this negedge
    task automatic expect_expiry(int edges, bit p, string tag);
        int r0 = n_rst, p0 = n_pwr;
        cycles(edges - 1);
        chk({tag, " no early pulse"}, n_rst + n_pwr, r0 + p0);
        @(negedge clk);
        chk({tag, " rst_req"}, {31'd0, rst_req}, {31'd0, !p});
        chk({tag, " pwroff_req"}, {31'd0, pwroff_req}, {31'd0, p});
        @(negedge clk);
        chk({tag, " single pulse"}, {31'd0, rst_req | pwroff_req}, 0);
        chk({tag, " pulse count"}, n_rst - r0 + n_pwr - p0, 1);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int r0, p0;
        cycles(3);
        por_rst_n = 1'b1; sys_rst_n = 1'b1;
        cycles(1);

        // R1 reset state
        rd(3'd0, d); chk("R1 ctl", d, 32'h0);
        rd(3'd4, d); chk("R1 timeout", d, 32'd60);
        chk("R1 req", {30'd0, rst_req, pwroff_req}, 0);
        // R7 disabled bit
        cfg_enable = 1'b0;
        rd(3'd0, d); chk("R7 disabled", d, 32'h8);
        cfg_enable = 1'b1;
        rd(3'd0, d); chk("R7 enabled", d, 32'h0);
        @(negedge clk);

        // R2 decode and access gate
        wr(3'd2, 32'hFF);
        rd(3'd2, d); chk("R2 other offset", d, 0);
        rd(3'd0, d); chk("R2 ignored write", d, 0);
        @(negedge clk);
        cfg_access = 1'b0;
        wr(3'd4, 32'd9);
        rd(3'd4, d); chk("R2 gated read", d, 0);
        cfg_access = 1'b1;
        rd(3'd4, d); chk("R2 gated write", d, 32'd60);
        @(negedge clk);

        // R9 reload field
        wr(3'd4, 32'd0);     rd(3'd4, d); chk("R9 zero ignored", d, 32'd60);
        @(negedge clk);
        wr(3'd4, 32'h7FF);   rd(3'd4, d); chk("R9 10-bit field", d, 32'h3FF);
        @(negedge clk);
        wr(3'd4, 32'h400);   rd(3'd4, d); chk("R9 low bits zero", d, 32'h3FF);
        @(negedge clk);

        // R3 trigger without run
        wr(3'd4, 32'd5);
        wr(3'd0, 32'h80);
        rd(3'd4, d); chk("R3 load", d, (32'd5 << 16) | 32'd5);
        rd(3'd0, d); chk("R3 trig reads 0", d, 0);
        cycles(3 * DIV);
        rd(3'd4, d); chk("R6 stopped holds", d, (32'd5 << 16) | 32'd5);
        @(negedge clk);

        // R4/R5 sweep over reload and action
        for (int t = 1; t <= 6; t++) begin
            for (int p = 0; p <= 1; p++) begin
                wr(3'd4, t);
                wr(3'd0, 32'h81 | (p << 2));
                expect_expiry(t * DIV, p[0], $sformatf("R5 T=%0d pwr=%0d", t, p));
                rd(3'd4, d); chk("R5 count stays 0", d, t);
                rd(3'd0, d); chk("R8 flag set", d, 32'h3 | (p << 2));
                r0 = n_rst; p0 = n_pwr;
                cycles(2 * DIV + 1);
                chk("R5 no repeat", n_rst + n_pwr, r0 + p0);
                wr(3'd0, 32'h3 | (p << 2));
                rd(3'd0, d); chk("R8 flag cleared", d, 32'h1 | (p << 2));
                @(negedge clk);
                wr(3'd0, 0);
            end
        end

        // R4 mid-count readback
        wr(3'd4, 32'd5);
        wr(3'd0, 32'h81);
        cycles(2 * DIV);
        rd(3'd4, d); chk("R4 live count", d, (32'd3 << 16) | 32'd5);
        @(negedge clk);
        rd(3'd4, d); chk("R4 between ticks", d, (32'd3 << 16) | 32'd5);
        expect_expiry(3 * DIV - 1, 1'b0, "R4 remaining");
        wr(3'd0, 32'h2);

        // R6 halt by run bit and resume
        wr(3'd4, 32'd6);
        wr(3'd0, 32'h81);
        cycles(2 * DIV);
        wr(3'd0, 32'h0);
        r0 = n_rst;
        cycles(10 * DIV);
        rd(3'd4, d); chk("R6 run halt holds", d, (32'd4 << 16) | 32'd6);
        chk("R6 no pulse when halted", n_rst, r0);
        @(negedge clk);
        wr(3'd0, 32'h1);
        expect_expiry(4 * DIV, 1'b0, "R6 resume run");
        wr(3'd0, 32'h2);

        // R6 halt by cfg_enable
        wr(3'd0, 32'h81);
        cycles(DIV);
        cfg_enable = 1'b0;
        cycles(10 * DIV);
        rd(3'd4, d); chk("R6 enable halt holds", d, (32'd5 << 16) | 32'd6);
        rd(3'd0, d); chk("R7 disabled while running", d, 32'h9);
        @(negedge clk);
        cfg_enable = 1'b1;
        expect_expiry(5 * DIV + 1, 1'b0, "R6 resume enable");
        wr(3'd0, 32'h2);

        // R10 retrigger postpones expiry
        wr(3'd4, 32'd3);
        wr(3'd0, 32'h81);
        r0 = n_rst;
        cycles(2 * DIV);
        wr(3'd0, 32'h81);
        chk("R10 no pulse before kick", n_rst, r0);
        expect_expiry(3 * DIV, 1'b0, "R10 kick");

        // R5 maximum reload with power-off action
        wr(3'd4, 32'd1023);
        wr(3'd0, 32'h85);
        expect_expiry(1023 * DIV, 1'b1, "R5 T=1023");

        // R8 flag survives system reset, not power-on reset
        sys_rst_n = 1'b0; cycles(2); sys_rst_n = 1'b1;
        rd(3'd0, d); chk("R8 survives sys reset", d, 32'h2);
        rd(3'd4, d); chk("R1 sys reset timeout", d, 32'd60);
        @(negedge clk);
        por_rst_n = 1'b0; cycles(2); por_rst_n = 1'b1;
        rd(3'd0, d); chk("R8 cleared by por", d, 32'h0);
        chk("R1 no req after por", {30'd0, rst_req, pwroff_req}, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule